// File: doc/BRIEF.md
# Dual-Bank Packet Receive Buffer

This block holds received bytes for one bulk OUT endpoint. Its storage is split into two equal banks, and each bank holds one packet of at most `BANK_BYTES` bytes. The default of 64 gives 128 bytes in total. The packet engine streams bytes into the bank that is currently open for writing. It then ends the packet with a status strobe that says whether the packet arrived intact. A good packet commits the bank and latches that bank's byte count. A bad packet rewinds the write pointer, so the bank fills again from byte zero.

The drain side can be a CPU or a DMA engine. It sees a full flag, the byte count of the oldest committed bank, and a byte stream from that bank. After taking the bytes, software pulses a release input, and the bank returns to the writer. Banks are committed and released alternately, so packets leave in the order they arrived, even while the next packet is landing in the other bank.

Both byte interfaces are valid/ready. On the write side, a byte is taken in a cycle where `in_valid` and `in_ready` are both high. `in_ready` falls when the open bank already holds `BANK_BYTES` bytes, or when both banks are committed; in the second case `nak` is high. On the read side, a byte moves in a cycle where `rd_valid` and `rd_ready` are both high. `rd_valid` falls once the whole committed count has been read, and stays low until the bank is released. A synchronous `clr` empties the buffer at any time.

Top module: `usbrx_dualbank`

## Requirements
- R1: After reset or a cycle with `clr` high: `full` = 0, `nak` = 0, `in_ready` = 1, `rd_valid` = 0 and `rd_count` = 0.
- R2: An end strobe with `eop_ok` = 1 commits the open bank. From the next cycle, `full` = 1. If that bank is the oldest committed one, `rd_count` equals the number of bytes taken for the packet, including a byte accepted in the same cycle as the strobe.
- R3: The read stream returns a committed packet's bytes in the order they were written.
- R4: An end strobe with `eop_ok` = 0 leaves `full` and `rd_count` unchanged. The next packet in that bank holds only its own bytes.
- R5: While both banks are committed, `nak` = 1 and `in_ready` = 0. Offered bytes and end strobes are ignored.
- R6: With two banks committed, the drain side sees the earlier packet first. After its release, it sees the later one.
- R7: A release keeps `full` at 1 while the other bank is still committed. `full` falls to 0 only when no committed bank remains.
- R8: A release pulse while no bank is committed has no effect.
- R9: Once the open bank holds `BANK_BYTES` bytes, `in_ready` = 0 until that packet ends.
- R10: After `rd_count` bytes have been read from a bank, `rd_valid` = 0 until the bank is released.
- R11: `clr` discards committed packets and any partly written one. The next packet is stored from byte zero of bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous buffer clear |
| in_valid | input | 1 | Received byte offered |
| in_ready | output | 1 | Byte can be taken |
| in_data | input | 8 | Received byte |
| eop_valid | input | 1 | Packet end strobe |
| eop_ok | input | 1 | Packet status with strobe: 1 good, 0 bad |
| nak | output | 1 | Both banks committed; the endpoint must refuse data |
| rd_valid | output | 1 | Byte available from the oldest committed bank |
| rd_ready | input | 1 | Drain side takes the byte |
| rd_data | output | 8 | Byte at the read pointer |
| rd_count | output | $clog2(BANK_BYTES+1) | Byte count of the oldest committed bank, 0 if none |
| full | output | 1 | At least one committed bank is unreleased |
| rel | input | 1 | Read-finished release pulse |

## Verification
The bench builds the block with `BANK_BYTES` = 8. This keeps the capacity limit of R9 within a few cycles and leaves the 7-bit address path of the default unused. With small banks, one scenario can fill a bank to the brim, fill both banks to hit the refuse condition, and interleave commits and releases so that both banks are used as oldest and as open. The bench also checks bank order across a bad packet, a stray release and a clear that arrives mid-packet.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  localparam int BANKS = 2;
  typedef logic [7:0] rx_byte_t;
endpackage

// File: rtl/usbrx_bank_mem.sv
module usbrx_bank_mem #(
  parameter int BANK_BYTES = 64,
  localparam int AW = $clog2(BANK_BYTES)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic                wr_bank,
  input  logic [AW-1:0]       wr_addr,
  input  usbrx_pkg::rx_byte_t wr_data,
  input  logic                rd_bank,
  input  logic [AW-1:0]       rd_addr,
  output usbrx_pkg::rx_byte_t rd_data
);
  usbrx_pkg::rx_byte_t bank_q [usbrx_pkg::BANKS];

  for (genvar b = 0; b < usbrx_pkg::BANKS; b++) begin : g_bank
    usbrx_pkg::rx_byte_t store [BANK_BYTES];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == b[0])) store[wr_addr] <= wr_data;
    end
    assign bank_q[b] = store[rd_addr];
  end

  assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/usbrx_wr_ctrl.sv
module usbrx_wr_ctrl #(
  parameter int BANK_BYTES = 64,
  localparam int AW = $clog2(BANK_BYTES),
  localparam int PW = $clog2(BANK_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          eop_valid,
  input  logic          eop_ok,
  input  logic          bank_busy,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wbank,
  output logic          commit,
  output logic [PW-1:0] commit_cnt
);
  logic [PW-1:0] wptr;
  logic          eop_take;

  assign in_ready   = !bank_busy && (wptr < PW'(BANK_BYTES));
  assign wr_en      = in_valid && in_ready;
  assign wr_addr    = wptr[AW-1:0];
  assign eop_take   = eop_valid && !bank_busy;
  assign commit     = eop_take && eop_ok;
  assign commit_cnt = wptr + PW'(wr_en);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      wbank <= 1'b0;
    end else if (eop_take) begin
      wptr <= '0;
      if (eop_ok) wbank <= ~wbank;
    end else if (wr_en) begin
      wptr <= wptr + 1'b1;
    end
  end

  AST_BANK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= PW'(BANK_BYTES)); // R9
  AST_BAD_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_take && !eop_ok) |=> (wptr == '0)); // R4
endmodule

// File: rtl/usbrx_rd_ctrl.sv
module usbrx_rd_ctrl #(
  parameter int BANK_BYTES = 64,
  localparam int AW = $clog2(BANK_BYTES),
  localparam int PW = $clog2(BANK_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bank_full,
  input  logic [PW-1:0] bank_cnt,
  input  logic          rd_ready,
  input  logic          rel,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic          rbank,
  output logic          rel_take,
  output logic [PW-1:0] rd_count
);
  logic [PW-1:0] rptr;

  assign rd_valid = bank_full && (rptr < bank_cnt);
  assign rd_addr  = rptr[AW-1:0];
  assign rel_take = rel && bank_full;
  assign rd_count = bank_full ? bank_cnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rptr  <= '0;
      rbank <= 1'b0;
    end else if (rel_take) begin
      rptr  <= '0;
      rbank <= ~rbank;
    end else if (rd_valid && rd_ready) begin
      rptr <= rptr + 1'b1;
    end
  end

  AST_REL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_take && !clr) |=> ((rptr == '0) && (rbank != $past(rbank)))); // R6
endmodule

// File: rtl/usbrx_dualbank.sv
module usbrx_dualbank #(
  parameter int BANK_BYTES = 64,
  localparam int AW = $clog2(BANK_BYTES),
  localparam int PW = $clog2(BANK_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          eop_valid,
  input  logic          eop_ok,
  output logic          nak,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [7:0]    rd_data,
  output logic [PW-1:0] rd_count,
  output logic          full,
  input  logic          rel
);
  logic [usbrx_pkg::BANKS-1:0] committed;
  logic [PW-1:0]               cnt_q [usbrx_pkg::BANKS];
  logic                        wr_en, wbank, commit, rbank, rel_take;
  logic [PW-1:0]               commit_cnt;
  logic [AW-1:0]               wr_addr, rd_addr;

  usbrx_wr_ctrl #(.BANK_BYTES(BANK_BYTES)) u_wr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .eop_valid(eop_valid), .eop_ok(eop_ok), .bank_busy(committed[wbank]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wbank(wbank), .commit(commit),
    .commit_cnt(commit_cnt));

  usbrx_rd_ctrl #(.BANK_BYTES(BANK_BYTES)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bank_full(committed[rbank]),
    .bank_cnt(cnt_q[rbank]), .rd_ready(rd_ready), .rel(rel), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rbank(rbank), .rel_take(rel_take), .rd_count(rd_count));

  usbrx_bank_mem #(.BANK_BYTES(BANK_BYTES)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_bank(wbank), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_bank(rbank), .rd_addr(rd_addr), .rd_data(rd_data));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      committed <= '0;
      for (int b = 0; b < usbrx_pkg::BANKS; b++) cnt_q[b] <= '0;
    end else begin
      if (commit) begin
        committed[wbank] <= 1'b1;
        cnt_q[wbank]     <= commit_cnt;
      end
      if (rel_take) committed[rbank] <= 1'b0;
    end
  end

  assign full = |committed;
  assign nak  = &committed;

  AST_NAK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> !in_ready); // R5
  AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_valid && eop_ok && !nak && !clr) |=> full); // R2
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!full && !rd_valid)); // R1
endmodule

// File: tb/tb_usbrx_dualbank.sv
module tb_usbrx_dualbank;
  localparam int BB = 8;
  localparam int PW = $clog2(BB + 1);

  logic clk = 0, rst_n = 0, clr = 0;
  logic in_valid = 0, eop_valid = 0, eop_ok = 0, rd_ready = 0, rel = 0;
  logic [7:0] in_data = 0;
  logic in_ready, nak, rd_valid, full;
  logic [7:0] rd_data;
  logic [PW-1:0] rd_count;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  usbrx_dualbank #(.BANK_BYTES(BB)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .eop_valid(eop_valid), .eop_ok(eop_ok), .nak(nak),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_count(rd_count),
    .full(full), .rel(rel));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic send_bytes(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = base + 8'(i);
      for (int w = 0; w < 50 && !in_ready; w++) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic end_pkt(input bit ok);
    @(negedge clk);
    eop_valid = 1; eop_ok = ok;
    @(negedge clk);
    eop_valid = 0; eop_ok = 0;
  endtask

  task automatic release_bank();
    @(negedge clk); rel = 1;
    @(negedge clk); rel = 0;
  endtask

  task automatic read_pkt(input string tag, input logic [7:0] base, input int n);
    @(negedge clk);
    chk_eq({tag, " count"}, int'(rd_count), n);
    rd_ready = 1;
    for (int i = 0; i < n; i++) begin
      chk_eq({tag, " valid"}, int'(rd_valid), 1);
      chk_eq({tag, " data"}, int'(rd_data), int'(base + 8'(i)));
      @(negedge clk);
    end
    rd_ready = 0;
    chk_eq("R10 valid after count", int'(rd_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_eq("R1 full", int'(full), 0);
    chk_eq("R1 nak", int'(nak), 0);
    chk_eq("R1 in_ready", int'(in_ready), 1);
    chk_eq("R1 rd_valid", int'(rd_valid), 0);
    chk_eq("R1 rd_count", int'(rd_count), 0);
  endtask

  task automatic t_single();
    send_bytes(8'h10, 5);
    end_pkt(1);
    chk_eq("R2 full", int'(full), 1);
    read_pkt("R3 single", 8'h10, 5);
    release_bank();
    chk_eq("R7 full clears", int'(full), 0);
  endtask

  task automatic t_bad();
    send_bytes(8'hA0, 3);
    end_pkt(0);
    chk_eq("R4 full after bad", int'(full), 0);
    chk_eq("R4 count after bad", int'(rd_count), 0);
    send_bytes(8'h30, 4);
    end_pkt(1);
    read_pkt("R4 after bad", 8'h30, 4);
    release_bank();
  endtask

  task automatic t_order();
    send_bytes(8'h40, 3);
    end_pkt(1);
    send_bytes(8'h50, 6);
    end_pkt(1);
    chk_eq("R5 nak", int'(nak), 1);
    chk_eq("R5 in_ready", int'(in_ready), 0);
    @(negedge clk); in_valid = 1; in_data = 8'hEE; eop_valid = 1; eop_ok = 1;
    @(negedge clk); @(negedge clk);
    in_valid = 0; eop_valid = 0; eop_ok = 0;
    read_pkt("R6 older first", 8'h40, 3);
    release_bank();
    chk_eq("R7 full held", int'(full), 1);
    chk_eq("R5 nak released", int'(nak), 0);
    read_pkt("R6 later second", 8'h50, 6);
    release_bank();
    chk_eq("R7 full cleared", int'(full), 0);
  endtask

  task automatic t_cap();
    send_bytes(8'h60, BB);
    @(negedge clk);
    chk_eq("R9 in_ready at cap", int'(in_ready), 0);
    chk_eq("R9 nak at cap", int'(nak), 0);
    in_valid = 1; in_data = 8'hFF;
    @(negedge clk); in_valid = 0;
    end_pkt(1);
    read_pkt("R9 full bank", 8'h60, BB);
    release_bank();
  endtask

  task automatic t_stray();
    release_bank();
    chk_eq("R8 full", int'(full), 0);
    send_bytes(8'h70, 2);
    end_pkt(1);
    read_pkt("R8 after stray release", 8'h70, 2);
    release_bank();
  endtask

  task automatic t_clear();
    send_bytes(8'h80, 3);
    end_pkt(1);
    send_bytes(8'h90, 3);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    chk_eq("R11 full", int'(full), 0);
    chk_eq("R11 count", int'(rd_count), 0);
    chk_eq("R11 in_ready", int'(in_ready), 1);
    chk_eq("R1 rd_valid after clr", int'(rd_valid), 0);
    send_bytes(8'hC0, 2);
    end_pkt(1);
    read_pkt("R11 after clear", 8'hC0, 2);
    release_bank();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_bad();
    t_order();
    t_cap();
    t_stray();
    t_clear();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule